// File: doc/BRIEF.md
# Reset Cause Controller

This block merges four reset requests into one core reset for a chip and records which kind of event caused it. The requests are an external active-low reset pin, an active-low power-on input, a supply-good level from a brown-out detector, and a continuous check of configuration words against complemented shadow copies. The core reset is asserted asynchronously. It is released synchronously, two clocks after the last request has ended.

The external pin is synchronized and debounced, so short low pulses do nothing. When the supply recovers from a brown-out, a power-up timer keeps the core in reset for a fixed number of cycles. A new dip during that window restarts the timer.

Three active-low cause flags sit in a small status register that software reads and writes. Software can only set a flag back to one. A hardware event clears its flag and wins over a write in the same cycle. A brown-out is told apart from a power-on by reading the power-on and brown-out flags together.

Top module: `rst_cause_ctrl`

## Requirements
- R1: `ext_rst_n` passes through two synchronizing flops. It requests reset only after staying low for `FILT_CYC` consecutive samples (default 16). A shorter pulse leaves `core_rst_n` high and all flags unchanged.
- R2: `ext_rst_n` is an input only. No internal source drives it. A reset from the pin leaves every flag unchanged.
- R3: The power-on flag is `flags` bit 1, active low. It is cleared to 0 only while `por_n` is low. No other reset changes it, and only a software write sets it to 1.
- R4: The brown-out flag is bit 0, active low. It is cleared on every brown-out and on every power-on. Brown-out is the cause when bit 0 = 0 and bit 1 = 1.
- R5: When `supply_ok` returns high after a brown-out, the core stays in reset for `PWRT_CYC` cycles (default 1024). A new low on `supply_ok` during that time reloads the timer from zero.
- R6: While `bor_en` = 0, a low `supply_ok` causes no reset and leaves the brown-out flag unchanged.
- R7: If any configuration word differs from the bitwise complement of its shadow copy, reset is held for as long as the mismatch lasts and the mismatch flag (bit 5, active low) is cleared. Power-on sets it to 1. Pin and brown-out resets leave it unchanged.
- R8: A write with `reg_wr` = 1 sets each flag whose `reg_wdata` bit is 1. A 0 bit has no effect. Bits 7:6 and 4:2 always read 0. A clearing event in the same cycle overrides the write.
- R9: `core_rst_n` goes low at once, without waiting for a clock edge, while any request or the timer is active. It rises only after two clock edges with no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| supply_ok | input | 1 | Supply-good level from the brown-out detector |
| bor_en | input | 1 | Enables brown-out detection |
| cfg_word | input | NUM_WORDS*WORD_W | Configuration words |
| cfg_shadow | input | NUM_WORDS*WORD_W | Complemented shadow copies |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status register write data |
| flags | output | 8 | Status register read value |
| core_rst_n | output | 1 | Core reset, active low |

## Verification
A software write that sets a flag can fall in the same cycle as the hardware event that clears that flag. The bench provokes this by holding `supply_ok` low, or by holding a configuration mismatch, while it writes a 1 to the matching flag bit. It then expects the flag to read back as 0. A second overlap is a supply dip that lands inside the power-up window. The bench judges it by finding the core still in reset at a point past the first window but inside a restarted one.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int FLG_BOR = 0;
    localparam int FLG_POR = 1;
    localparam int FLG_CM  = 5;

    typedef struct packed {
        logic cm_n;
        logic por_n;
        logic bor_n;
    } cause_flags_t;

    function automatic logic [7:0] pack_flags(input cause_flags_t f);
        logic [7:0] v;
        v          = 8'h00;
        v[FLG_BOR] = f.bor_n;
        v[FLG_POR] = f.por_n;
        v[FLG_CM]  = f.cm_n;
        return v;
    endfunction

endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int FILT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic active
);
    localparam int CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], pin_n};
        if (st_q.sync[1]) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CW'(FILT_CYC)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= 2'b11;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = (st_q.cnt == CW'(FILT_CYC));

    // R1: the request rises only after the synchronized pin was low
    a_r1_low_before_act: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(!st_q.sync[1]));
    // R1: a high synchronized pin always drops the request
    a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sync[1] |=> !active);

endmodule

// File: rtl/rstc_brownout.sv
module rstc_brownout #(
    parameter int PWRT_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic bor_en,
    output logic bor_act,
    output logic tmr_run
);
    localparam int TW = $clog2(PWRT_CYC + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          run;
        logic [TW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    assign bor_act = bor_en && !st_q.sync[1];
    assign tmr_run = st_q.run;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], supply_ok};
        if (bor_act) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.run) begin
            if (st_q.cnt == TW'(PWRT_CYC - 1)) begin
                st_d.run = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= 2'b11;
            st_q.run  <= 1'b0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: a brown-out in any cycle reloads the timer from zero
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        bor_act |=> (st_q.run && st_q.cnt == '0));
    // R6: with detection disabled no brown-out is reported
    a_r6_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !bor_en |-> !bor_act);

endmodule

// File: rtl/rstc_cfg_check.sv
module rstc_cfg_check #(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_WORDS*WORD_W-1:0] cfg_word,
    input  logic [NUM_WORDS*WORD_W-1:0] cfg_shadow,
    output logic                        cm_act
);
    typedef struct packed {
        logic hit;
    } state_t;

    state_t               st_d, st_q;
    logic [NUM_WORDS-1:0] word_bad;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign word_bad[w] = |(cfg_word[w*WORD_W +: WORD_W] ^
                               ~cfg_shadow[w*WORD_W +: WORD_W]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.hit = |word_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cm_act = st_q.hit;

    // R7: a registered mismatch follows a compare failure by one cycle
    a_r7_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word != ~cfg_shadow) |=> cm_act);

endmodule

// File: rtl/rstc_flags.sv
module rstc_flags
    import rstc_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       bor_evt,
    input  logic       cm_evt,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] flags
);
    cause_flags_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.bor_n = st_q.bor_n | wdata[FLG_BOR];
            st_d.por_n = st_q.por_n | wdata[FLG_POR];
            st_d.cm_n  = st_q.cm_n  | wdata[FLG_CM];
        end
        if (bor_evt) st_d.bor_n = 1'b0;
        if (cm_evt)  st_d.cm_n  = 1'b0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.bor_n <= 1'b0;
            st_q.por_n <= 1'b0;
            st_q.cm_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = pack_flags(st_q);

    // R3: the power-on flag stays 0 until software writes it
    a_r3_por_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (!st_q.por_n && !(wr && wdata[FLG_POR])) |=> !st_q.por_n);
    // R4: a brown-out event leaves the flag at 0
    a_r4_bor_clear: assert property (@(posedge clk) disable iff (!por_n)
        bor_evt |=> !flags[FLG_BOR]);
    // R7: a mismatch event leaves the flag at 0
    a_r7_cm_clear: assert property (@(posedge clk) disable iff (!por_n)
        cm_evt |=> !flags[FLG_CM]);
    // R8: a flag rises only through a write with that bit set
    a_r8_set_by_write: assert property (@(posedge clk) disable iff (!por_n)
        $rose(flags[FLG_BOR]) |-> $past(wr && wdata[FLG_BOR]));
    // R8: unused bits read 0
    a_r8_unused_zero: assert property (@(posedge clk) disable iff (!por_n)
        (flags & 8'hDC) == 8'h00);

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl #(
    parameter int FILT_CYC  = 16,
    parameter int PWRT_CYC  = 1024,
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 16
) (
    input  logic                        clk,
    input  logic                        por_n,
    input  logic                        ext_rst_n,
    input  logic                        supply_ok,
    input  logic                        bor_en,
    input  logic [NUM_WORDS*WORD_W-1:0] cfg_word,
    input  logic [NUM_WORDS*WORD_W-1:0] cfg_shadow,
    input  logic                        reg_wr,
    input  logic [7:0]                  reg_wdata,
    output logic [7:0]                  flags,
    output logic                        core_rst_n
);
    logic pin_act;
    logic bor_act;
    logic tmr_run;
    logic cm_act;
    logic hold;

    typedef struct packed {
        logic [1:0] stage;
    } rsync_t;

    rsync_t rs_d, rs_q;

    rstc_pin_filter #(.FILT_CYC(FILT_CYC)) i_pin (
        .clk    (clk),
        .rst_n  (por_n),
        .pin_n  (ext_rst_n),
        .active (pin_act)
    );

    rstc_brownout #(.PWRT_CYC(PWRT_CYC)) i_bor (
        .clk       (clk),
        .rst_n     (por_n),
        .supply_ok (supply_ok),
        .bor_en    (bor_en),
        .bor_act   (bor_act),
        .tmr_run   (tmr_run)
    );

    rstc_cfg_check #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) i_cfg (
        .clk        (clk),
        .rst_n      (por_n),
        .cfg_word   (cfg_word),
        .cfg_shadow (cfg_shadow),
        .cm_act     (cm_act)
    );

    rstc_flags i_flags (
        .clk     (clk),
        .por_n   (por_n),
        .bor_evt (bor_act),
        .cm_evt  (cm_act),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .flags   (flags)
    );

    assign hold = !por_n || pin_act || bor_act || tmr_run || cm_act;

    always_comb begin
        rs_d       = rs_q;
        rs_d.stage = {rs_q.stage[0], 1'b1};
    end

    always_ff @(posedge clk or posedge hold) begin
        if (hold) rs_q <= '0;
        else      rs_q <= rs_d;
    end

    assign core_rst_n = rs_q.stage[1];

    // R9: any active request holds the core in reset
    a_r9_hold_low: assert property (@(posedge clk) disable iff (!por_n)
        (pin_act || bor_act || tmr_run || cm_act) |-> !core_rst_n);
    // R9: release only after two quiet edges
    a_r9_release: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_rst_n) |-> $past(!hold));
    // R2: a pin reset changes no flag
    a_r2_pin_no_flag: assert property (@(posedge clk) disable iff (!por_n)
        (pin_act && !reg_wr && !bor_act && !cm_act) |=> $stable(flags));

endmodule

// File: tb/test_rst_cause_ctrl.sv
module test_rst_cause_ctrl;
    localparam int FILT = 16;
    localparam int PWRT = 1024;
    localparam int NW   = 4;
    localparam int WW   = 16;

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             ext_rst_n = 1'b1;
    logic             supply_ok = 1'b1;
    logic             bor_en = 1'b1;
    logic [NW*WW-1:0] cfg_word = 64'h0123_4567_89AB_CDEF;
    logic [NW*WW-1:0] cfg_shadow = ~64'h0123_4567_89AB_CDEF;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_wdata = 8'h00;
    logic [7:0]       flags;
    logic             core_rst_n;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;
    bit  saw_low = 0;

    typedef struct {
        int       req;
        logic     rst_n;
        logic [7:0] fl;
        bit       use_saw;
        bit       saw;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    rst_cause_ctrl #(.FILT_CYC(FILT), .PWRT_CYC(PWRT), .NUM_WORDS(NW), .WORD_W(WW)) i_rst_cause_ctrl (
        .clk        (clk),
        .por_n      (por_n),
        .ext_rst_n  (ext_rst_n),
        .supply_ok  (supply_ok),
        .bor_en     (bor_en),
        .cfg_word   (cfg_word),
        .cfg_shadow (cfg_shadow),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .flags      (flags),
        .core_rst_n (core_rst_n)
    );

    always @(negedge clk) if (core_rst_n !== 1'b1) saw_low = 1'b1;

    // monitor: pops expectations and compares at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (core_rst_n !== e.rst_n) begin
                errors++;
                $display("FAIL R%0d core_rst_n actual %b expected %b", e.req, core_rst_n, e.rst_n);
            end
            checks++;
            if (flags !== e.fl) begin
                errors++;
                $display("FAIL R%0d flags actual %h expected %h", e.req, flags, e.fl);
            end
            if (e.use_saw) begin
                checks++;
                if (saw_low !== e.saw) begin
                    errors++;
                    $display("FAIL R%0d reset seen actual %b expected %b", e.req, saw_low, e.saw);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_st(input int req, input logic r, input logic [7:0] f);
        exp_t e;
        e.req = req; e.rst_n = r; e.fl = f; e.use_saw = 0; e.saw = 0;
        sb_q.push_back(e);
        cyc(1);
    endtask

    task automatic expect_saw(input int req, input logic r, input logic [7:0] f, input bit s);
        exp_t e;
        e.req = req; e.rst_n = r; e.fl = f; e.use_saw = 1; e.saw = s;
        sb_q.push_back(e);
        cyc(1);
    endtask

    task automatic wr_reg(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        cyc(1);
        reg_wr = 1'b0; reg_wdata = 8'h00;
        cyc(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(3);
        // R3 R4 R7: reset state during power-on
        expect_st(3, 1'b0, 8'h20);
        por_n = 1'b1;
        cyc(6);
        // R9: released after power-on, cause reads power-on
        expect_st(9, 1'b1, 8'h20);

        // R8: writes set flags only
        wr_reg(8'h23);
        expect_st(8, 1'b1, 8'h23);
        wr_reg(8'h00);
        expect_st(8, 1'b1, 8'h23);
        wr_reg(8'hFF);
        expect_st(8, 1'b1, 8'h23);

        // R1: pulse one sample short of the filter length is ignored
        saw_low = 0;
        ext_rst_n = 1'b0; cyc(FILT - 1); ext_rst_n = 1'b1;
        cyc(10);
        expect_saw(1, 1'b1, 8'h23, 1'b0);

        // R1 R2: a long pulse resets without touching flags
        saw_low = 0;
        ext_rst_n = 1'b0; cyc(FILT + 10);
        expect_st(2, 1'b0, 8'h23);
        ext_rst_n = 1'b1; cyc(8);
        expect_saw(2, 1'b1, 8'h23, 1'b1);

        // R4: brown-out decoded as BOR=0, POR=1
        supply_ok = 1'b0; cyc(10);
        expect_st(4, 1'b0, 8'h22);
        // R8: set of BOR loses to a brown-out in the same cycle
        wr_reg(8'h01);
        expect_st(8, 1'b0, 8'h22);

        // R5: power-up timer and restart on a dip
        supply_ok = 1'b1; cyc(PWRT - 50);
        expect_st(5, 1'b0, 8'h22);
        supply_ok = 1'b0; cyc(3); supply_ok = 1'b1;
        cyc(PWRT - 50);
        expect_st(5, 1'b0, 8'h22);
        cyc(100);
        expect_st(5, 1'b1, 8'h22);

        // R6: detection disabled ignores a supply drop
        wr_reg(8'h01);
        bor_en = 1'b0;
        saw_low = 0;
        supply_ok = 1'b0; cyc(20); supply_ok = 1'b1; cyc(5);
        expect_saw(6, 1'b1, 8'h23, 1'b0);
        bor_en = 1'b1; cyc(5);

        // R7: mismatch in one word holds reset and clears the flag
        cfg_shadow[2*WW + 3] = ~cfg_shadow[2*WW + 3];
        cyc(6);
        expect_st(7, 1'b0, 8'h03);
        // R8: set of CM loses to a live mismatch
        wr_reg(8'h20);
        expect_st(8, 1'b0, 8'h03);
        cfg_shadow[2*WW + 3] = ~cfg_shadow[2*WW + 3];
        cyc(6);
        expect_st(7, 1'b1, 8'h03);
        // R7: a brown-out leaves CM unchanged
        supply_ok = 1'b0; cyc(5); supply_ok = 1'b1;
        cyc(PWRT + 20);
        expect_st(7, 1'b1, 8'h02);
        wr_reg(8'h21);
        expect_st(8, 1'b1, 8'h23);

        // R3 R4: a new power-on clears POR and BOR
        por_n = 1'b0; cyc(3);
        expect_st(3, 1'b0, 8'h20);
        por_n = 1'b1; cyc(6);
        expect_st(4, 1'b1, 8'h20);

        cyc(3);
        finish_run();
    end

endmodule